// File: doc/BRIEF.md
# Split-ROM high-bank cartridge address decoder

This block is a purely combinational address decoder for a high-bank cartridge whose program ROM is larger than 32 Mbit and is therefore built from two devices: a large primary ROM and a smaller secondary ROM. It watches the 24-bit system bus address together with active-high read and write strobes. From these it drives a chip select and a linear address for each ROM, and a chip select and a linear address for a battery-backed SRAM.

The top address bit picks the physical ROM and never acts as a mirror bit. With it high, the primary ROM is visible. With it low, the secondary ROM is visible. Within each half, the banks that have address bit 22 set show whole 64 KB banks. The banks that have bit 22 clear show only the upper 32 KB of each bank, and that data is the same as the upper half of the matching whole bank. Save RAM is placed only in the lower-half window of banks 80-BF. Banks 7E-7F belong to the console and are never decoded.

Top module: `hirom_split_decoder`

## Requirements
- R1: A read in banks C0-FF selects the primary ROM (only `pri_cs`), with `pri_addr` = ((bank mod 64) * 65536 + offset) mod 2^PRI_AW.
- R2: A read in banks 80-BF at offsets 8000-FFFF selects the primary ROM, with the same `pri_addr` that the same offset in bank (bank + 0x40) would give.
- R3: A read in banks 40-7D selects the secondary ROM (only `sec_cs`), with `sec_addr` = ((bank mod 64) * 65536 + offset) mod 2^SEC_AW. With the default SEC_AW = 21, banks 60-7D therefore repeat the data of banks 40-5D.
- R4: A read in banks 00-3F at offsets 8000-FFFF selects the secondary ROM, with the same `sec_addr` that the same offset in bank (bank + 0x40) would give.
- R5: A read or a write in banks 80-BF at offsets 6000-7FFF selects the SRAM (only `ram_cs`), with `ram_addr` = ((bank mod 64) * 8192 + (offset mod 8192)) mod 2^RAM_AW.
- R6: In banks 00-3F and 80-BF, offsets 0000-7FFF that lie outside the R5 window assert no select. Banks 00-3F never select the SRAM, and this includes offsets 6000-7FFF.
- R7: Banks 7E and 7F assert no select, whatever the strobes are.
- R8: The ROM selects need `rd` high: a write alone never selects either ROM. With both strobes low, every select is low.
- R9: For every address and every strobe pattern, at most one of `pri_cs`, `sec_cs` and `ram_cs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_addr | input | 24 | System bus address: bank in bits 23:16, offset in bits 15:0 |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| pri_cs | output | 1 | Primary ROM select, active high |
| pri_addr | output | PRI_AW | Primary ROM linear address |
| sec_cs | output | 1 | Secondary ROM select, active high |
| sec_addr | output | SEC_AW | Secondary ROM linear address |
| ram_cs | output | 1 | SRAM select, active high |
| ram_addr | output | RAM_AW | SRAM linear address |

## Verification
Two functions can fall in the same cycle: a ROM read and an SRAM access. This happens when `rd` and `wr` are both high at once. It also happens at the 7FFF/8000 seam of banks 80-BF, where the SRAM window sits next to the mirrored primary-ROM half. The bench sweeps every bank against offsets on both sides of each seam, under all four strobe patterns. Each output is judged against a model computed arithmetically from bank and offset: the model gives the one expected select and its linear address, and it expects no select on ROM for a write alone.

// File: rtl/hirom_split_decoder.sv
module hirom_split_decoder #(
  parameter int PRI_AW = 22,
  parameter int SEC_AW = 21,
  parameter int RAM_AW = 15
) (
  input  logic [23:0]       bus_addr,
  input  logic              rd,
  input  logic              wr,
  output logic              pri_cs,
  output logic [PRI_AW-1:0] pri_addr,
  output logic              sec_cs,
  output logic [SEC_AW-1:0] sec_addr,
  output logic              ram_cs,
  output logic [RAM_AW-1:0] ram_addr
);

  localparam int RAM_FULL = 19;

  logic [RAM_FULL-1:0] ram_lin;
  logic                console_bank;
  logic                rom_hit;
  logic                ram_win;

  assign ram_lin  = {bus_addr[21:16], bus_addr[12:0]};
  assign pri_addr = bus_addr[PRI_AW-1:0];
  assign sec_addr = bus_addr[SEC_AW-1:0];
  assign ram_addr = ram_lin[RAM_AW-1:0];

  always_comb begin
    console_bank = (bus_addr[23:17] == 7'b0111111);
    rom_hit      = !console_bank && (bus_addr[22] || bus_addr[15]);
    ram_win      = (bus_addr[23:22] == 2'b10) && (bus_addr[15:13] == 3'b011);
    pri_cs       = rd && rom_hit && bus_addr[23];
    sec_cs       = rd && rom_hit && !bus_addr[23];
    ram_cs       = (rd || wr) && ram_win;

    p_one_select_r9: assert ($onehot0({pri_cs, sec_cs, ram_cs}));
    p_console_quiet_r7: assert (!(bus_addr[23:16] == 8'h7E || bus_addr[23:16] == 8'h7F)
                               || !(pri_cs || sec_cs || ram_cs));
    p_rom_needs_read_r8: assert (!(pri_cs || sec_cs) || rd);
    p_ram_banks_r5: assert (!ram_cs || (bus_addr[23:22] == 2'b10 && bus_addr[15:13] == 3'b011));
    p_low_half_rom_r6: assert (bus_addr[22] || bus_addr[15] || !(pri_cs || sec_cs));
  end

endmodule

// File: tb/hirom_split_decoder_bench.sv
module hirom_split_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PRI_AW = 22;
  localparam int SEC_AW = 21;
  localparam int RAM_AW = 15;

  logic clk = 0;
  logic rst = 1;
  logic [23:0] bus_addr = '0;
  logic rd = 0, wr = 0;
  logic pri_cs, sec_cs, ram_cs;
  logic [PRI_AW-1:0] pri_addr;
  logic [SEC_AW-1:0] sec_addr;
  logic [RAM_AW-1:0] ram_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hirom_split_decoder #(.PRI_AW(PRI_AW), .SEC_AW(SEC_AW), .RAM_AW(RAM_AW)) u_hirom_split_decoder (
    .bus_addr(bus_addr), .rd(rd), .wr(wr),
    .pri_cs(pri_cs), .pri_addr(pri_addr),
    .sec_cs(sec_cs), .sec_addr(sec_addr),
    .ram_cs(ram_cs), .ram_addr(ram_addr));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s addr=%06h rd=%0d wr=%0d actual=%0h expected=%0h", tag, bus_addr, rd, wr, act, exp);
    end
  endtask

  int offs [12] = '{0, 1, 'h1234, 'h5FFF, 'h6000, 'h6001, 'h6A5A, 'h7FFF, 'h8000, 'h8001, 'hABCD, 'hFFFF};

  initial begin
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    bus_addr = 24'hC08000; rd = 0; wr = 0; #1;
    chk("R8 idle pri", pri_cs, 0);
    chk("R8 idle sec", sec_cs, 0);
    chk("R8 idle ram", ram_cs, 0);

    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 12; k++) begin
        for (int s = 0; s < 4; s++) begin
          int o;
          bit r, w, wram, pri_e, sec_e, ram_e;
          string tag;
          longint lin;
          o = offs[k];
          r = s[0]; w = s[1];
          bus_addr = 24'(b * 65536 + o); rd = r; wr = w;
          #1;
          wram  = (b == 126 || b == 127);
          pri_e = r && !wram && (b >= 192 || (b >= 128 && o >= 32768));
          sec_e = r && !wram && ((b >= 64 && b < 126) || (b < 64 && o >= 32768));
          ram_e = (r || w) && b >= 128 && b < 192 && o >= 24576 && o < 32768;
          if (wram) tag = "R7";
          else if (b >= 192) tag = "R1";
          else if (b >= 128 && o >= 32768) tag = "R2";
          else if (b >= 64) tag = "R3";
          else if (o >= 32768) tag = "R4";
          else if (ram_e) tag = "R5";
          else tag = "R6";
          if (!r && (b >= 64 || o >= 32768)) tag = "R8";
          chk({tag, " pri_cs"}, pri_cs, pri_e);
          chk({tag, " sec_cs"}, sec_cs, sec_e);
          chk({tag, " ram_cs"}, ram_cs, ram_e);
          chk("R9 onehot", (32'(pri_cs) + 32'(sec_cs) + 32'(ram_cs)) <= 1, 1);
          lin = longint'((b % 64) * 65536 + o);
          if (pri_e) chk({tag, " pri_addr"}, pri_addr, lin % (64'd1 << PRI_AW));
          if (sec_e) chk({tag, " sec_addr"}, sec_addr, lin % (64'd1 << SEC_AW));
          if (ram_e) chk("R5 ram_addr", ram_addr,
                         longint'((b % 64) * 8192 + (o % 8192)) % (64'd1 << RAM_AW));
          #1;
        end
      end
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule